// File: doc/BRIEF.md
# Power-of-Two Clock Output Divider with Fanout

This block divides a source clock by 1, 2, 4 or 8 and sends the result to several identical complementary output pairs. The source is one of two inputs. A primary tick stream stands in for the synthesizer oscillator. A reference tick stream is used when the oscillator is bypassed.

The block is modelled on a fast system clock. Each single-cycle tick marks one edge of the source clock, so two ticks make one source period. The output toggles after a number of counted ticks equal to the selected ratio. This gives a 50% duty cycle at every setting, including pass-through.

A ratio register holds the active setting. It samples the select code only when the output rises, so both halves of every output period use the same ratio. A master reset parks the outputs (true low, complement high) and holds the counter. It leaves the active ratio untouched. A separate power-on reset restores the default ratio of ÷2.

Top module: `fdiv_pow2`

## Requirements
- R1: After `por` the active ratio is ÷2. The first output high phase after reset begins once two ticks have been counted, whatever `div_sel` holds.
- R2: The `div_sel` code maps to a half-period in counted ticks: 00 → 1, 01 → 2, 10 → 4, 11 → 8. These correspond to division by 1, 2, 4 and 8 of a source whose period is two ticks.
- R3: The high phase and the low phase of each output period last the same number of counted ticks, whatever the spacing of the ticks.
- R4: While `mr` is high, every `q` bit is 0 and every `qn` bit is 1 from the next clock edge on. Ticks during that time are not counted.
- R5: `mr` does not change the active ratio. After release, the first low phase lasts the ratio that was active before `mr`, even if `div_sel` changed meanwhile.
- R6: With `src_vco` = 1 only `vco_tick` is counted. With `src_vco` = 0 only `ref_tick` is counted, and the unselected stream has no effect on the outputs.
- R7: All `q` bits are equal at all times, and each `qn` bit is the inverse of its `q` bit.
- R8: A new `div_sel` code is taken into the active ratio only on the clock edge where the output rises. It then governs that high phase and the following low phase.
- R9: The output changes on the clock edge that samples the tick completing the half-period. With no counted ticks, the output holds its level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on reset, active high; restores default ratio |
| mr | input | 1 | Synchronous master reset, active high; parks outputs, keeps ratio |
| src_vco | input | 1 | 1: count `vco_tick`; 0: bypass, count `ref_tick` |
| vco_tick | input | 1 | One-cycle pulse per oscillator edge |
| ref_tick | input | 1 | One-cycle pulse per reference edge |
| div_sel | input | 2 | Requested ratio code (00 ÷1, 01 ÷2, 10 ÷4, 11 ÷8) |
| q | output | NPAIR | True outputs |
| qn | output | NPAIR | Complement outputs |

## Verification
Every code is first run with a tick on every cycle. This separates the four half-period lengths and exposes any code mapped to the wrong ratio. Sparse random ticks then show whether phases count ticks rather than clock cycles, and only the sparse patterns catch a divider that drifts from 50% duty. Streams that tick only on the unselected source separate a correct bypass selector from one that merges or swaps the two. Select changes in mid-period, and a master reset applied together with a code change, distinguish the latch on the rising edge and the kept ratio from a design that loads the code at once or clears it on reset.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Width of the ratio select code.
    localparam int SEL_W    = 2;
    // Largest half-period in counted ticks (code all ones).
    localparam int HALF_MAX = 1 << ((1 << SEL_W) - 1);
    localparam int CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

    typedef enum logic [SEL_W-1:0] {
        DIV_1 = 2'd0,
        DIV_2 = 2'd1,
        DIV_4 = 2'd2,
        DIV_8 = 2'd3
    } div_code_e;

    localparam div_code_e POR_CODE = DIV_2;

    typedef struct packed {
        logic             phase;
        logic [CNT_W-1:0] cnt;
        div_code_e        code;
    } div_state_t;

    // Terminal count of a half-period for a given code.
    function automatic logic [CNT_W-1:0] last_count(input div_code_e c);
        return CNT_W'((32'd1 << c) - 32'd1);
    endfunction

endpackage

// File: rtl/fdiv_src_mux.sv
module fdiv_src_mux (
    input  logic use_vco,
    input  logic vco_tick,
    input  logic ref_tick,
    output logic tick
);
    // Bypass steers the reference through the same divider.
    assign tick = use_vco ? vco_tick : ref_tick;
endmodule

// File: rtl/fdiv_core.sv
module fdiv_core
    import fdiv_pkg::*;
(
    input  logic      clk,
    input  logic      por,
    input  logic      mr,
    input  logic      tick,
    input  div_code_e sel_i,
    output logic      phase_o,
    output div_code_e code_o
);
    div_state_t st;
    logic       at_end;

    assign at_end = (st.cnt == last_count(st.code));

    always_ff @(posedge clk) begin
        if (por) begin
            st.phase <= 1'b0;
            st.cnt   <= '0;
            st.code  <= POR_CODE;
        end else if (mr) begin
            // Counter and output parked; ratio kept.
            st.phase <= 1'b0;
            st.cnt   <= '0;
        end else if (tick) begin
            if (at_end) begin
                st.phase <= ~st.phase;
                st.cnt   <= '0;
                // Ratio only moves when the output is about to rise.
                if (!st.phase) begin
                    st.code <= sel_i;
                end
            end else begin
                st.cnt <= st.cnt + 1'b1;
            end
        end
    end

    assign phase_o = st.phase;
    assign code_o  = st.code;
endmodule

// File: rtl/fdiv_fanout.sv
module fdiv_fanout #(
    parameter int NPAIR = 4
) (
    input  logic             phase,
    output logic [NPAIR-1:0] q,
    output logic [NPAIR-1:0] qn
);
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        assign q[i]  = phase;
        assign qn[i] = ~phase;
    end
endmodule

// File: rtl/fdiv_pow2.sv
module fdiv_pow2
    import fdiv_pkg::*;
#(
    parameter int NPAIR = 4
) (
    input  logic             clk,
    input  logic             por,
    input  logic             mr,
    input  logic             src_vco,
    input  logic             vco_tick,
    input  logic             ref_tick,
    input  logic [SEL_W-1:0] div_sel,
    output logic [NPAIR-1:0] q,
    output logic [NPAIR-1:0] qn
);
    logic      src_tick;
    logic      phase;
    div_code_e active_code;

    fdiv_src_mux u_mux (
        .use_vco  (src_vco),
        .vco_tick (vco_tick),
        .ref_tick (ref_tick),
        .tick     (src_tick)
    );

    fdiv_core u_core (
        .clk     (clk),
        .por     (por),
        .mr      (mr),
        .tick    (src_tick),
        .sel_i   (div_code_e'(div_sel)),
        .phase_o (phase),
        .code_o  (active_code)
    );

    fdiv_fanout #(.NPAIR(NPAIR)) u_fan (
        .phase (phase),
        .q     (q),
        .qn    (qn)
    );
endmodule

// File: rtl/fdiv_pow2_chk.sv
module fdiv_pow2_chk #(
    parameter int NPAIR = 4
) (
    input logic             clk,
    input logic             por,
    input logic             mr,
    input logic             src_vco,
    input logic             vco_tick,
    input logic             ref_tick,
    input logic [NPAIR-1:0] q,
    input logic [NPAIR-1:0] qn,
    input logic [1:0]       code
);
    logic sel_tick;
    assign sel_tick = src_vco ? vco_tick : ref_tick;

    // R4: master reset parks the true outputs low.
    p_mr_parks_r4: assert property (@(posedge clk) disable iff (por)
        mr |=> (q == '0));

    // R7: pairs match and are complementary.
    p_pairs_match_r7: assert property (@(posedge clk) disable iff (por)
        (qn == ~q) && ((q == '0) || (q == '1)));

    // R6 / R9: no counted tick, no output change.
    p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (por)
        (!sel_tick && !mr) |=> $stable(q));

    // R1: power-on reset restores the ÷2 code.
    p_por_default_r1: assert property (@(posedge clk)
        por |=> (code == 2'b01));

    // R8: ratio changes only together with a rising output.
    p_ratio_on_rise_r8: assert property (@(posedge clk) disable iff (por)
        !$stable(code) |-> $rose(q[0]));

    // R5: master reset leaves the ratio alone.
    p_mr_keeps_ratio_r5: assert property (@(posedge clk) disable iff (por)
        mr |=> $stable(code));
endmodule

bind fdiv_pow2 fdiv_pow2_chk #(.NPAIR(NPAIR)) u_chk (
    .clk      (clk),
    .por      (por),
    .mr       (mr),
    .src_vco  (src_vco),
    .vco_tick (vco_tick),
    .ref_tick (ref_tick),
    .q        (q),
    .qn       (qn),
    .code     (active_code)
);

// File: tb/test_fdiv_pow2.sv
module test_fdiv_pow2;
    localparam int CLK_PERIOD = 10;
    localparam int NPAIR      = 4;

    logic             clk = 1'b0;
    logic             por = 1'b1;
    logic             mr  = 1'b0;
    logic             src_vco  = 1'b1;
    logic             vco_tick = 1'b0;
    logic             ref_tick = 1'b0;
    logic [1:0]       div_sel  = 2'b11;
    logic [NPAIR-1:0] q, qn;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state: output level, ticks counted, active code.
    int m_q    = 0;
    int m_cnt  = 0;
    int m_code = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdiv_pow2 #(.NPAIR(NPAIR)) i_fdiv_pow2 (
        .clk(clk), .por(por), .mr(mr), .src_vco(src_vco),
        .vco_tick(vco_tick), .ref_tick(ref_tick), .div_sel(div_sel),
        .q(q), .qn(qn)
    );

    function automatic int half_len(input int code);
        return 1 << code;
    endfunction

    task automatic compare(input string tag);
        logic [NPAIR-1:0] exp_q;
        exp_q = (m_q != 0) ? '1 : '0;
        checks++;
        if (q !== exp_q) begin
            fails++;
            $display("FAIL %s q actual=%b expected=%b t=%0t", tag, q, exp_q, $time);
        end
        checks++;
        if (qn !== ~exp_q) begin
            fails++;
            $display("FAIL R7 qn actual=%b expected=%b t=%0t", qn, ~exp_q, $time);
        end
    endtask

    // Check the state left by the last edge, then drive the next inputs.
    task automatic cyc(input logic p, input logic m, input logic s,
                       input logic vt, input logic rt, input logic [1:0] sel,
                       input string tag);
        logic t;
        @(negedge clk);
        compare(tag);
        por = p; mr = m; src_vco = s; vco_tick = vt; ref_tick = rt; div_sel = sel;
        t = s ? vt : rt;
        if (p) begin
            m_q = 0; m_cnt = 0; m_code = 1;
        end else if (m) begin
            m_q = 0; m_cnt = 0;
        end else if (t) begin
            if (m_cnt == half_len(m_code) - 1) begin
                m_q   = 1 - m_q;
                m_cnt = 0;
                if (m_q == 1) m_code = int'(sel);
            end else begin
                m_cnt++;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // Reset state.
        cyc(1, 0, 1, 0, 0, 2'b11, "R1");
        cyc(1, 0, 1, 1, 1, 2'b11, "R1");
        cyc(1, 0, 1, 1, 1, 2'b11, "R4");
        // R1: default ÷2 governs the first low phase.
        for (int i = 0; i < 30; i++) cyc(0, 0, 1, 1, 0, 2'b11, "R1");
        // R2: each code with dense ticks.
        for (int c = 0; c < 4; c++)
            for (int i = 0; i < 48; i++) cyc(0, 0, 1, 1, 0, 2'(c), "R2");
        // R3: sparse ticks, equal phases in ticks.
        for (int i = 0; i < 400; i++)
            cyc(0, 0, 1, ($urandom % 3) == 0, 0, 2'(i / 100), "R3");
        // R6: bypass, only the unselected stream ticks, then the reference.
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, 0, 2'b00, "R6");
        for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 1, 2'b00, "R6");
        for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, 1, 2'b01, "R6");
        // R4 / R5: load ÷8, reset while changing the code, release.
        for (int i = 0; i < 40; i++) cyc(0, 0, 1, 1, 0, 2'b11, "R5");
        for (int i = 0; i < 6; i++)  cyc(0, 1, 1, 1, 1, 2'b00, "R4");
        for (int i = 0; i < 30; i++) cyc(0, 0, 1, 1, 0, 2'b00, "R5");
        // R8: code changes in mid-period.
        for (int i = 0; i < 200; i++)
            cyc(0, 0, 1, 1, 0, 2'((i / 5) % 4), "R8");
        // R9: no ticks, output holds.
        for (int i = 0; i < 20; i++) cyc(0, 0, 1, 0, 0, 2'b10, "R9");
        // Random mix.
        for (int i = 0; i < 3000; i++)
            cyc(0, ($urandom % 64) == 0, ($urandom % 8) != 0,
                ($urandom % 2) == 0, ($urandom % 2) == 0,
                2'($urandom % 4), "R8");
        @(negedge clk);
        compare("R3");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule